// File: doc/BRIEF.md
# Read/Write Buffer with Write-Path FIFO

This block sits between two 18-bit ports, A and B. Words heading from A to B go through a four-entry synchronous queue. The queue has one clock, separate active-low load and unload enables, an active-low full indication and a registered output word that feeds port B. Words heading from B to A go through a level-sensitive capture latch.

Each port has its own active-low drive control. The block returns it as a drive-enable output, next to the data output, so the pad ring can build the tri-state driver. A typical use is a posted-write buffer between a fast master and a slow target, with the latch holding read-back data for the master.

Top module: `rw_buffer`

## Requirements
- R1: On a rising clock edge with rst_ni high, wr_en_ni low and fewer than four words stored, the word on a_i is appended to the queue. Words leave in the order they were stored.
- R2: On a rising clock edge with rst_ni high, rd_en_ni low and at least one word stored, the oldest word is removed and appears on b_o after that edge. b_o changes only on an edge that performs an unload or a reset.
- R3: full_no is low exactly when four words are stored and high otherwise.
- R4: A rising edge with rst_ni low empties the queue, sets every bit of b_o to 1 and leaves full_no high. This holds whatever the levels of wr_en_ni and rd_en_ni.
- R5: A load request while four words are stored (and no unload on that edge) is discarded. The stored words and b_o are unchanged.
- R6: An unload request while the queue is empty has no effect. b_o keeps its previous word.
- R7: With both enables low on one edge, the edge behaves as follows:
  - an empty queue performs only the load;
  - a full queue performs only the unload;
  - any other occupancy performs both.
- R8: While latch_en_i is high, a_o follows b_i. When latch_en_i falls, a_o keeps the b_i value present at that moment until latch_en_i rises again.
- R9: b_oe_o is high exactly when b_drv_ni is low. a_oe_o is high exactly when a_drv_ni is low. The drive controls do not alter a_o or b_o.
- R10: The queue and the latch are independent. Latch activity and b_i do not affect b_o or full_no, and queue activity does not affect a_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Queue clock |
| rst_ni | input | 1 | Synchronous reset of the queue, active low |
| wr_en_ni | input | 1 | Load enable, active low |
| rd_en_ni | input | 1 | Unload enable, active low |
| full_no | output | 1 | Queue full, active low |
| a_i | input | 18 | Port A input data (queue load side) |
| a_drv_ni | input | 1 | Port A drive control, active low |
| a_o | output | 18 | Port A output data from the latch |
| a_oe_o | output | 1 | Port A driver enable |
| b_i | input | 18 | Port B input data (latch side) |
| b_drv_ni | input | 1 | Port B drive control, active low |
| b_o | output | 18 | Port B output data from the queue register |
| b_oe_o | output | 1 | Port B driver enable |
| latch_en_i | input | 1 | Latch transparency enable, active high |

## Verification
b_o and full_no are both state after a single register, so each is due on the first rising edge after its enables and reset are applied. a_o and the two drive enables are combinational and settle within the same cycle. The bench changes inputs on the falling edge. At the next rising edge a reference queue model records the expected b_o and full_no, and a monitor compares them on the following falling edge, one edge after the stimulus. Latch and drive-enable results are sampled one time unit after their inputs change, with no clock involved.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  parameter int unsigned WORD_W     = 18;
  parameter int unsigned FIFO_DEPTH = 4;
endpackage

// File: rtl/rwb_fifo.sv
module rwb_fifo #(
  parameter int unsigned W     = rwb_pkg::WORD_W,
  parameter int unsigned DEPTH = rwb_pkg::FIFO_DEPTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_ni,
  input  logic         rd_en_ni,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         full_no
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     rdata_q;
  logic             empty, full, do_wr, do_rd;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_FULL);
  // boundary rule: empty favours the load, full favours the unload
  assign do_wr = !wr_en_ni && !full;
  assign do_rd = !rd_en_ni && !empty;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      rdata_q  <= '1;
    end else begin
      if (do_wr) begin
        mem_q[wr_ptr_q] <= wdata_i;
        wr_ptr_q        <= ptr_inc(wr_ptr_q);
      end
      if (do_rd) begin
        rdata_q  <= mem_q[rd_ptr_q];
        rd_ptr_q <= ptr_inc(rd_ptr_q);
      end
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign full_no = !full;
endmodule

// File: rtl/rwb_latch.sv
module rwb_latch #(
  parameter int unsigned W = rwb_pkg::WORD_W
) (
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_l;

  always_latch begin
    if (le_i) q_l = d_i;
  end

  assign q_o = q_l;
endmodule

// File: rtl/rwb_drive.sv
module rwb_drive #(
  parameter int unsigned W = rwb_pkg::WORD_W
) (
  input  logic         drv_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o,
  output logic         oe_o
);
  assign d_o  = d_i;
  assign oe_o = !drv_ni;
endmodule

// File: rtl/rw_buffer.sv
module rw_buffer #(
  parameter int unsigned W     = rwb_pkg::WORD_W,
  parameter int unsigned DEPTH = rwb_pkg::FIFO_DEPTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_ni,
  input  logic         rd_en_ni,
  output logic         full_no,
  input  logic [W-1:0] a_i,
  input  logic         a_drv_ni,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  input  logic         b_drv_ni,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  input  logic         latch_en_i
);
  logic [W-1:0] fifo_q, latch_q;

  rwb_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_ni (wr_en_ni),
    .rd_en_ni (rd_en_ni),
    .wdata_i  (a_i),
    .rdata_o  (fifo_q),
    .full_no  (full_no)
  );

  rwb_latch #(.W(W)) i_latch (
    .le_i (latch_en_i),
    .d_i  (b_i),
    .q_o  (latch_q)
  );

  rwb_drive #(.W(W)) i_drv_b (
    .drv_ni (b_drv_ni),
    .d_i    (fifo_q),
    .d_o    (b_o),
    .oe_o   (b_oe_o)
  );

  rwb_drive #(.W(W)) i_drv_a (
    .drv_ni (a_drv_ni),
    .d_i    (latch_q),
    .d_o    (a_o),
    .oe_o   (a_oe_o)
  );
endmodule

// File: rtl/rwb_checker.sv
module rwb_checker #(
  parameter int unsigned W = rwb_pkg::WORD_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_ni,
  input logic         rd_en_ni,
  input logic         full_no,
  input logic [W-1:0] b_o,
  input logic [W-1:0] a_o,
  input logic         latch_en_i
);
  logic rst_seen_q;

  always_ff @(posedge clk_i) rst_seen_q <= !rst_ni;

  // R4: one edge after reset, output all ones and not full
  always @(posedge clk_i) begin
    if (rst_seen_q === 1'b1) begin
      a_r4_reset_state: assert (b_o == '1 && full_no == 1'b1);
    end
  end

  // R2 / R6: no unload request, output word unchanged
  a_r2_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_ni |=> $stable(b_o));

  // R3 / R5: full stays full without an unload
  a_r5_full_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && rd_en_ni) |=> !full_no);

  // R3: full can only be reached through a load
  a_r3_full_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_no) |-> $past(!wr_en_ni));

  // R8: opaque latch keeps its value
  a_r8_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_en_i && $past(!latch_en_i)) |-> $stable(a_o));
endmodule

bind rw_buffer rwb_checker #(.W(W)) i_rwb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_ni   (wr_en_ni),
  .rd_en_ni   (rd_en_ni),
  .full_no    (full_no),
  .b_o        (b_o),
  .a_o        (a_o),
  .latch_en_i (latch_en_i)
);

// File: tb/test_rw_buffer.sv
module test_rw_buffer;
  localparam int W = 18;
  localparam int DEPTH = 4;
  localparam time CLK_PERIOD = 10;

  typedef struct {
    logic [W-1:0] b;
    logic         ff;
    string        req;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0, wr_en_ni = 1'b1, rd_en_ni = 1'b1;
  logic         a_drv_ni = 1'b1, b_drv_ni = 1'b1, latch_en_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] a_o, b_o;
  logic         full_no, a_oe_o, b_oe_o;

  int checks = 0, errors = 0;
  exp_t exp_q[$];
  logic [W-1:0] mdl_q[$];
  logic [W-1:0] mdl_out = '1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rw_buffer i_rw_buffer (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_ni(wr_en_ni), .rd_en_ni(rd_en_ni),
    .full_no(full_no), .a_i(a_i), .a_drv_ni(a_drv_ni), .a_o(a_o), .a_oe_o(a_oe_o),
    .b_i(b_i), .b_drv_ni(b_drv_ni), .b_o(b_o), .b_oe_o(b_oe_o), .latch_en_i(latch_en_i)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one clock with given controls, model records the expectation
  task automatic step(input bit rst, input bit wr, input bit rd,
                      input logic [W-1:0] d, input string req);
    bit rd_ok, wr_ok;
    exp_t e;
    @(negedge clk_i);
    rst_ni = !rst; wr_en_ni = !wr; rd_en_ni = !rd; a_i = d;
    @(posedge clk_i);
    if (rst) begin
      mdl_q.delete();
      mdl_out = '1;
    end else begin
      rd_ok = rd && mdl_q.size() > 0;
      wr_ok = wr && mdl_q.size() < DEPTH;
      if (rd_ok) mdl_out = mdl_q.pop_front();
      if (wr_ok) mdl_q.push_back(d);
    end
    e.b = mdl_out; e.ff = !(mdl_q.size() == DEPTH); e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: compare one edge after the stimulus
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check({e.req, " b_o"}, b_o, e.b);
      check({e.req, " full_no"}, W'(full_no), W'(e.ff));
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R4: reset state
    step(1, 0, 0, '0, "R4");
    step(1, 0, 0, '0, "R4");
    // R1 / R3: fill
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, W'(18'h10 + i), "R1_R3");
    // R5: write while full discarded
    step(0, 1, 0, 18'h3_abcd, "R5");
    // R2: unload in order
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, '0, "R2");
    // R6: unload empty keeps last word
    step(0, 0, 1, '0, "R6");
    step(0, 0, 0, '0, "R6");
    // R4: reset wins over both enables
    step(0, 1, 0, 18'h2_2222, "R1");
    step(1, 1, 1, 18'h0_5555, "R4");
    // R7: simultaneous at empty
    step(0, 1, 1, 18'h1_1111, "R7");
    step(0, 1, 0, 18'h1_2222, "R7");
    step(0, 1, 1, 18'h1_3333, "R7");
    step(0, 1, 0, 18'h1_4444, "R7");
    step(0, 1, 0, 18'h1_5555, "R7");
    // R7: simultaneous at full
    step(0, 1, 1, 18'h1_6666, "R7");
    step(0, 1, 1, 18'h1_7777, "R7");
    // mixed traffic, latch toggling (R10)
    for (int i = 0; i < 60; i++) begin
      latch_en_i = i[1];
      b_i = W'(i * 77);
      step(0, (i % 3) != 0, (i % 4) != 1, W'(i * 1237 + 5), "R10");
    end
    latch_en_i = 1'b0;
    step(1, 0, 0, '0, "R4");
    wait (exp_q.size() == 0);
    @(negedge clk_i);

    // R8: transparency and capture
    latch_en_i = 1'b1; b_i = 18'h0_a5a5; #1;
    check("R8 transparent", a_o, 18'h0_a5a5);
    b_i = 18'h3_0f0f; #1;
    check("R8 follow", a_o, 18'h3_0f0f);
    latch_en_i = 1'b0; #1;
    b_i = 18'h1_ffff; #1;
    check("R8 hold", a_o, 18'h3_0f0f);
    // R10: queue traffic leaves latch alone
    step(0, 1, 0, 18'h0_0042, "R10");
    step(0, 0, 1, '0, "R10");
    wait (exp_q.size() == 0);
    @(negedge clk_i); #1;
    check("R10 latch", a_o, 18'h3_0f0f);
    // R9: drive enables
    a_drv_ni = 1'b1; b_drv_ni = 1'b1; #1;
    check("R9 a off", W'(a_oe_o), '0);
    check("R9 b off", W'(b_oe_o), '0);
    a_drv_ni = 1'b0; #1;
    check("R9 a on", W'(a_oe_o), W'(1));
    check("R9 b still off", W'(b_oe_o), '0);
    check("R9 a data", a_o, 18'h3_0f0f);
    b_drv_ni = 1'b0; #1;
    check("R9 b on", W'(b_oe_o), W'(1));
    check("R9 b data", b_o, 18'h0_0042);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule